// File: doc/BRIEF.md
# Strobe-Sampled Serial EEPROM Target

This block is the target side of a two-wire serial EEPROM holding up to 256 bytes. It does not oversample the bus. Instead, an upstream agent presents the current SCL and SDA levels together with a one-cycle update strobe. The block compares each sample with the previous one to find clock rising edges and START and STOP conditions. It then walks a bit-slot counter through three phases. The first phase is an eight-bit command byte. The second is an address byte when the command is a write, or a data byte when it is a read. Acknowledge slots separate the phases, and in each one the target pulls SDA low.

The strobe works as a valid qualifier with no ready. The target never applies back-pressure: every strobed sample is consumed in the cycle it arrives, and the line levels are ignored on cycles without a strobe. The level the target presents on SDA comes back on `sda_out`. It follows the sampled input, except in slots where the target drives the line. The contents are read-only and are generated from two parameters. A write command only sets the address pointer and fetches that byte. A later read command shifts the fetched byte out. Two variants are supported: 256 bytes, or 128 bytes with the address folded.

Top module: `sbb_eeprom`

## Requirements
- R1: After reset, `sda_out` is 1, `proto_err` is 0, the target is idle, and the data register holds 0x00, so a read issued before any address write returns 0x00.
- R2: A START is seen when SCL is high in both the previous and the current sample while SDA falls. A START opens a new transaction from any state and clears the command byte.
- R3: A STOP is seen when SCL is high in both samples while SDA rises. A STOP returns the target to idle, where later clock edges shift nothing and produce no acknowledge.
- R4: While idle with no acknowledge pending, all line activity other than a START is ignored, and after each strobe `sda_out` equals the sampled SDA.
- R5: The first eight SCL rising edges after a START shift SDA into the command byte, MSB first. On the ninth rising edge the target drives an acknowledge (`sda_out` = 0).
- R6: If bit 0 of the command is 0 (write), the next eight rising edges shift in the address, MSB first. The byte at that address is fetched when the last address bit arrives, and the following rising edge drives an acknowledge.
- R7: If bit 0 of the command is 1 (read), the next eight rising edges present the data register on `sda_out`, MSB first, one bit per edge.
- R8: The address is never incremented. A read phase ends by refetching the byte at the unchanged address, so back-to-back reads return the same byte.
- R9: After the acknowledge that follows the second byte, rising edges are ignored (`sda_out` follows SDA) until a START or STOP.
- R10: An SDA change sampled together with an SCL rising edge during a bit slot of either byte raises `proto_err` for exactly one cycle. The target then returns to idle and waits for a START.
- R11: The byte at address a is (a' * INIT_MUL + INIT_ADD) mod 256, where a' is a reduced to its low ADDR_BITS bits. With ADDR_BITS = 7, addresses 128 to 255 alias addresses 0 to 127.
- R12: Cycles without `line_valid` change no state. `sda_out` holds and `proto_err` stays 0 whatever SCL and SDA do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_valid | input | 1 | Update strobe; marks `scl_in`/`sda_in` as a new sample |
| scl_in | input | 1 | Sampled SCL level |
| sda_in | input | 1 | Sampled SDA level |
| sda_out | output | 1 | SDA level seen on the bus including the target's drive |
| proto_err | output | 1 | One-cycle pulse on a protocol violation |

## Verification
Every result is registered on the clock edge that takes the strobed sample, so `sda_out` and `proto_err` are due exactly one edge after the strobe. The bench drives each sample on a falling edge, holds the strobe for one cycle, and reads the outputs at the next falling edge. That falling edge comes after the consuming rising edge and before any later sample. Data bits and acknowledges are read immediately after the strobe carrying the SCL rise. The error pulse is read after the offending strobe and read again, expecting 0, after the following one. A sweep over all 256 addresses compares each returned byte with the value computed from the R11 formula.

// File: rtl/sbb_eeprom_pkg.sv
package sbb_eeprom_pkg;

  localparam int unsigned SLOT_W = 5;
  localparam logic [SLOT_W-1:0] SLOT_IDLE = 5'd0;
  localparam logic [SLOT_W-1:0] SLOT_FIRST = 5'd1;
  localparam logic [SLOT_W-1:0] SLOT_CMD_LAST = 5'd8;
  localparam logic [SLOT_W-1:0] SLOT_BYTE2_LAST = 5'd16;
  localparam logic [SLOT_W-1:0] SLOT_DONE = 5'd17;

  function automatic logic [7:0] ee_init_byte(input int unsigned idx,
                                              input int unsigned mul,
                                              input int unsigned add);
    int unsigned v;
    v = idx * mul + add;
    return v[7:0];
  endfunction

endpackage

// File: rtl/ee_line_sampler.sv
module ee_line_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic upd,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_rise,
  output logic start_det,
  output logic stop_det,
  output logic sda_chg
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else if (upd) begin
      scl_q <= scl_in;
      sda_q <= sda_in;
    end
  end

  assign scl_rise  = upd & ~scl_q & scl_in;
  assign start_det = upd & scl_q & scl_in & sda_q & ~sda_in;
  assign stop_det  = upd & scl_q & scl_in & ~sda_q & sda_in;
  assign sda_chg   = sda_q ^ sda_in;
endmodule

// File: rtl/ee_rom.sv
module ee_rom #(
  parameter int unsigned ADDR_BITS = 8,
  parameter int unsigned INIT_MUL  = 29,
  parameter int unsigned INIT_ADD  = 90
) (
  input  logic [ADDR_BITS-1:0] addr,
  output logic [7:0]           rdata
);
  import sbb_eeprom_pkg::*;
  localparam int unsigned DEPTH = 1 << ADDR_BITS;

  logic [7:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    assign mem[g] = ee_init_byte(g, INIT_MUL, INIT_ADD);
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/ee_ctrl.sv
module ee_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       upd,
  input  logic       sda_in,
  input  logic       scl_rise,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic       sda_chg,
  input  logic [7:0] rom_data,
  output logic [7:0] rom_addr,
  output logic       sda_out,
  output logic       proto_err
);
  import sbb_eeprom_pkg::*;

  logic [SLOT_W-1:0] slot;
  logic              ack_pend;
  logic [7:0]        cmd, addr, data;

  // Lookahead: on a write the last address bit is still arriving, so fetch
  // from the address as it will be after this shift.
  assign rom_addr = cmd[0] ? addr : {addr[6:0], sda_in};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot      <= SLOT_IDLE;
      ack_pend  <= 1'b0;
      cmd       <= 8'h00;
      addr      <= 8'h00;
      data      <= 8'h00;
      sda_out   <= 1'b1;
      proto_err <= 1'b0;
    end else begin
      proto_err <= 1'b0;
      if (upd) sda_out <= sda_in;
      if (start_det) begin
        slot     <= SLOT_FIRST;
        cmd      <= 8'h00;
        ack_pend <= 1'b0;
      end else if (stop_det) begin
        slot     <= SLOT_IDLE;
        ack_pend <= 1'b0;
      end else if (slot == SLOT_IDLE && !ack_pend) begin
        // idle: wait for START
      end else if (scl_rise) begin
        if (ack_pend) begin
          sda_out  <= 1'b0;
          ack_pend <= 1'b0;
        end else if (slot >= SLOT_DONE) begin
          // transaction finished: wait for START or STOP
        end else if (sda_chg) begin
          proto_err <= 1'b1;
          slot      <= SLOT_IDLE;
        end else if (slot <= SLOT_CMD_LAST) begin
          cmd  <= {cmd[6:0], sda_in};
          slot <= slot + 1'b1;
          if (slot == SLOT_CMD_LAST) ack_pend <= 1'b1;
        end else begin
          if (cmd[0]) begin
            sda_out <= data[7];
            data    <= {data[6:0], 1'b0};
          end else begin
            addr <= {addr[6:0], sda_in};
          end
          slot <= slot + 1'b1;
          if (slot == SLOT_BYTE2_LAST) begin
            data     <= rom_data;
            ack_pend <= 1'b1;
          end
        end
      end
    end
  end

  // Assertions
  assert_start_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (slot == SLOT_FIRST && !ack_pend && cmd == 8'h00));
  assert_stop_idles_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (slot == SLOT_IDLE && !ack_pend));
  assert_idle_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && slot == SLOT_IDLE && !ack_pend && !start_det) |=> (sda_out == $past(sda_in)));
  assert_err_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> !proto_err);
  assert_err_idles_R10: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> (slot == SLOT_IDLE && !ack_pend));
  assert_no_strobe_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> ($stable(sda_out) && !proto_err && $stable(slot)));
  assert_slot_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    slot <= SLOT_DONE);
endmodule

// File: rtl/sbb_eeprom.sv
module sbb_eeprom #(
  parameter int unsigned ADDR_BITS = 8,
  parameter int unsigned INIT_MUL  = 29,
  parameter int unsigned INIT_ADD  = 90
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_valid,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_out,
  output logic proto_err
);
  logic       scl_rise, start_det, stop_det, sda_chg;
  logic [7:0] rom_addr, rom_data;

  ee_line_sampler u_sampler (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd       (line_valid),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .scl_rise  (scl_rise),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_chg   (sda_chg)
  );

  ee_rom #(
    .ADDR_BITS (ADDR_BITS),
    .INIT_MUL  (INIT_MUL),
    .INIT_ADD  (INIT_ADD)
  ) u_rom (
    .addr  (rom_addr[ADDR_BITS-1:0]),
    .rdata (rom_data)
  );

  ee_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd       (line_valid),
    .sda_in    (sda_in),
    .scl_rise  (scl_rise),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_chg   (sda_chg),
    .rom_data  (rom_data),
    .rom_addr  (rom_addr),
    .sda_out   (sda_out),
    .proto_err (proto_err)
  );
endmodule

// File: tb/sbb_eeprom_bench.sv
module sbb_eeprom_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic upd = 1'b0;
  logic scl_i = 1'b1;
  logic sda_i = 1'b1;
  logic sel = 1'b0;
  logic sda_a, err_a, sda_b, err_b;
  logic sda_o, err_o;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sbb_eeprom u_sbb_eeprom (
    .clk(clk), .rst_n(rst_n), .line_valid(upd & ~sel),
    .scl_in(scl_i), .sda_in(sda_i), .sda_out(sda_a), .proto_err(err_a));

  sbb_eeprom #(.ADDR_BITS(7)) u_small (
    .clk(clk), .rst_n(rst_n), .line_valid(upd & sel),
    .scl_in(scl_i), .sda_in(sda_i), .sda_out(sda_b), .proto_err(err_b));

  assign sda_o = sel ? sda_b : sda_a;
  assign err_o = sel ? err_b : err_a;

  function automatic int exp_byte(input int a, input int bits);
    return (((a & ((1 << bits) - 1)) * 29) + 90) & 255;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic strobe(input bit c, input bit d);
    @(negedge clk);
    scl_i = c; sda_i = d; upd = 1'b1;
    @(negedge clk);
    upd = 1'b0;
  endtask

  task automatic send_bit(input bit b);
    strobe(0, b); strobe(1, b); strobe(0, b);
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic rise_check(input string req, input bit exp);
    strobe(0, 1); strobe(1, 1);
    chk(req, sda_o, exp);
    strobe(0, 1);
  endtask

  task automatic start_c();
    strobe(0, 1); strobe(1, 1); strobe(1, 0); strobe(0, 0);
  endtask

  task automatic stop_c();
    strobe(0, 0); strobe(1, 0); strobe(1, 1);
  endtask

  task automatic read_byte(output logic [7:0] v);
    v = 8'h00;
    for (int i = 0; i < 8; i++) begin
      strobe(0, 1); strobe(1, 1);
      v = {v[6:0], sda_o};
      strobe(0, 1);
    end
  endtask

  task automatic set_addr(input logic [7:0] a);
    start_c(); send_byte(8'hA0); rise_check("R5 cmd ack", 0);
    send_byte(a); rise_check("R6 addr ack", 0);
  endtask

  task automatic read_txn(output logic [7:0] v);
    start_c(); send_byte(8'hA1); rise_check("R5 read cmd ack", 0);
    read_byte(v);
  endtask

  initial begin
    logic [7:0] v, v2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 sda_out", sda_a, 1); chk("R1 err", err_a, 0);
    chk("R1 small sda_out", sda_b, 1); chk("R1 small err", err_b, 0);
    // R4 idle: output follows input, no shifting
    strobe(0, 0); strobe(1, 0); chk("R4 idle follow 0", sda_o, 0);
    strobe(0, 1); strobe(1, 1); chk("R4 idle follow 1", sda_o, 1);
    // R1 data register cleared: read before any address
    read_txn(v); chk("R1 data after reset", v, 0); stop_c();
    // R6 R7 R11 sweep over all addresses
    for (int a = 0; a < 256; a++) begin
      set_addr(8'(a));
      read_txn(v);
      chk("R11 sweep byte", v, exp_byte(a, 8));
      stop_c();
    end
    // R8 no auto-increment
    set_addr(8'h33); read_txn(v); stop_c(); read_txn(v2);
    chk("R8 first read", v, exp_byte(8'h33, 8));
    chk("R8 repeat read", v2, exp_byte(8'h33, 8));
    // R9 after final ack, edges ignored
    rise_check("R9 data ack", 0);
    rise_check("R9 ignored edge", 1);
    strobe(0, 0); strobe(1, 0); chk("R9 follow 0", sda_o, 0); strobe(0, 0);
    rise_check("R9 no further ack", 1);
    stop_c();
    // R3 stop mid-command, then no ack at ninth edge
    start_c(); send_bit(1); send_bit(0); send_bit(1); send_bit(0);
    stop_c();
    send_byte(8'hA0); rise_check("R3 no ack after stop", 1);
    // R10 protocol violation
    start_c(); send_bit(1); send_bit(0); send_bit(1);
    strobe(0, 0); strobe(1, 1); chk("R10 err pulse", err_o, 1);
    strobe(0, 1); chk("R10 err single", err_o, 0);
    send_byte(8'hA0); rise_check("R10 idle after err", 1);
    chk("R10 no err in idle", err_o, 0);
    // R2 START restarts from mid-transaction
    start_c(); send_bit(1); send_bit(1);
    start_c(); send_byte(8'hA0); rise_check("R2 restart ack at 9", 0);
    send_byte(8'h44); rise_check("R2 addr ack", 0);
    read_txn(v); chk("R2 read after restart", v, exp_byte(8'h44, 8)); stop_c();
    // R12 activity without strobe has no effect
    start_c(); send_byte(8'hA0); rise_check("R12 cmd ack", 0);
    send_bit(0); send_bit(0); send_bit(0); send_bit(1);
    v2 = {7'd0, sda_o};
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      scl_i = i[0]; sda_i = i[1];
      @(negedge clk);
      chk("R12 hold sda_out", sda_o, v2);
      chk("R12 no err", err_o, 0);
    end
    send_bit(0); send_bit(0); send_bit(0); send_bit(0);
    rise_check("R12 addr ack", 0);
    read_txn(v); chk("R12 byte", v, exp_byte(8'h10, 8)); stop_c();
    // R11 128-byte variant aliases upper half
    sel = 1'b1;
    set_addr(8'h85); read_txn(v); stop_c();
    chk("R11 alias 0x85", v, exp_byte(8'h85, 7));
    set_addr(8'h05); read_txn(v); stop_c();
    chk("R11 small 0x05", v, exp_byte(8'h05, 7));
    set_addr(8'hFF); read_txn(v); stop_c();
    chk("R11 alias 0xFF", v, exp_byte(8'hFF, 7));
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule